// File: doc/BRIEF.md
# Palette Grayscale Converter

This block turns a contiguous run of colour-lookup entries into gray levels, rewriting them in place. A controller gives it a first index and a number of entries. For each entry, the block reads the stored red, green and blue components. It forms a luma-weighted intensity in fixed point, rounds it, limits it to the component range, and stores that one value back into all three components of the same entry.

The block owns the palette's single internal port while it runs. That port carries an address, a synchronous read path with one cycle of latency, a write data bus and a write strobe. A blanking output stays high for the whole pass so that the display does not show a half-converted palette. A one-cycle completion pulse marks the end of the pass. Converting the whole palette means starting at index 0 with a count equal to the palette depth.

Top module: `pal_gray_engine`

## Requirements
- R1: The written intensity is I = (77*R + 151*G + 28*B + 128) >> 8. The sum is formed in at least 16 bits, so it never overflows.
- R2: An intensity above 63 is limited to 63. A full-scale entry (63,63,63) converts to 63.
- R3: The entry layout is red in bits [17:12], green in bits [11:6] and blue in bits [5:0]. The computed intensity is written to all three fields of the entry it was read from.
- R4: Entries are visited in ascending order from the first index through first+count-1. The index wraps from 255 to 0. Entries outside that range are never written.
- R5: Each entry takes three cycles: address out (read), compute, then write. Exactly one write strobe falls on the third cycle, and the address holds steady from the read cycle to the write cycle.
- R6: The blanking output is high from the cycle after an accepted non-zero start until the final write. It goes low together with the busy output.
- R7: The completion output pulses high for exactly one cycle, in the cycle after the final write. For N entries, this is 3N cycles after the start edge.
- R8: A start with count 0 pulses completion in the following cycle. It makes no writes and leaves blanking low.
- R9: A start request while a pass is running is ignored. The pass keeps its original range and timing.
- R10: A count of 256 starting at index 0 converts every entry of the palette.
- R11: After reset the block is idle, with busy, blanking, completion and write strobe all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| base_i | input | 8 | First palette index of the pass |
| count_i | input | 9 | Number of entries to convert (0 to 256) |
| busy_o | output | 1 | A pass is in progress |
| blank_o | output | 1 | Screen blanking request |
| done_o | output | 1 | One-cycle completion pulse |
| pal_addr_o | output | 8 | Palette port address |
| pal_rdata_i | input | 18 | Palette read data, valid one cycle after the address |
| pal_wdata_o | output | 18 | Palette write data |
| pal_we_o | output | 1 | Palette write strobe |

## Verification
The in-line properties check some rules on every cycle. Blanking must track busy. Write strobes never fall on adjacent cycles. The address holds from read to write, and it steps by one with wrap after each non-final write. A completion pulse does not repeat unless a new start arrives. A zero-count start finishes at once with no write. A busy start does not disturb the pass. Other behaviour shows only in the bench's scenarios, because it needs the palette contents. That covers whether the arithmetic, rounding and limiting give the right gray value, whether the right entries are written in the right order, whether untouched entries survive (including across the wrap), and whether the full-palette pass completes with the exact cycle count.

// File: rtl/pal_gray_pkg.sv
package pal_gray_pkg;

    localparam int COMP_W = 6;
    localparam int SUM_W  = 16;
    localparam int ENT_W  = 3 * COMP_W;

    localparam int WT_RED  = 77;
    localparam int WT_GRN  = 151;
    localparam int WT_BLU  = 28;
    localparam int RND_ADD = 128;
    localparam int FRAC_SH = 8;

    localparam logic [COMP_W-1:0] COMP_MAX = '1;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CALC  = 2'd2,
        ST_WRITE = 2'd3
    } eng_state_e;

    function automatic logic [COMP_W-1:0] clamp_comp(input logic [SUM_W-1:0] v);
        if (v > SUM_W'(COMP_MAX))
            return COMP_MAX;
        return v[COMP_W-1:0];
    endfunction

    function automatic rgb_t gray_entry(input logic [COMP_W-1:0] g);
        rgb_t e;
        e.red = g;
        e.grn = g;
        e.blu = g;
        return e;
    endfunction

endpackage

// File: rtl/pal_gray_luma.sv
module pal_gray_luma
    import pal_gray_pkg::*;
(
    input  rgb_t              pix_i,
    output logic [COMP_W-1:0] gray_o
);

    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] scaled;

    always_comb begin
        acc = SUM_W'(WT_RED) * SUM_W'(pix_i.red)
            + SUM_W'(WT_GRN) * SUM_W'(pix_i.grn)
            + SUM_W'(WT_BLU) * SUM_W'(pix_i.blu)
            + SUM_W'(RND_ADD);
        scaled = acc >> FRAC_SH;
        gray_o = clamp_comp(scaled);
    end

endmodule

// File: rtl/pal_gray_walker.sv
module pal_gray_walker #(
    parameter int  DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          step_i,
    output logic [AW-1:0] idx_o,
    output logic          last_o
);

    localparam logic [AW-1:0] TOP_IDX = AW'(DEPTH - 1);

    logic [AW-1:0] idx_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            left_q <= '0;
        end else if (load_i) begin
            idx_q  <= base_i;
            left_q <= count_i;
        end else if (step_i) begin
            idx_q  <= (idx_q == TOP_IDX) ? '0 : idx_q + AW'(1);
            left_q <= left_q - CW'(1);
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (left_q == CW'(1));

endmodule

// File: rtl/pal_gray_engine.sv
module pal_gray_engine
    import pal_gray_pkg::*;
#(
    parameter int  PAL_DEPTH = 256,
    localparam int AW        = $clog2(PAL_DEPTH),
    localparam int CW        = $clog2(PAL_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [AW-1:0]    base_i,
    input  logic [CW-1:0]    count_i,
    output logic             busy_o,
    output logic             blank_o,
    output logic             done_o,
    output logic [AW-1:0]    pal_addr_o,
    input  logic [ENT_W-1:0] pal_rdata_i,
    output logic [ENT_W-1:0] pal_wdata_o,
    output logic             pal_we_o
);

    eng_state_e        st_q, st_d;
    logic [COMP_W-1:0] gray_q;
    logic [COMP_W-1:0] gray_w;
    logic              done_q;
    logic              blank_q;
    logic              accept;
    logic              zero_req;
    logic              load;
    logic              step;
    logic              last_w;
    logic              finish;
    logic [AW-1:0]     idx_w;
    rgb_t              pix_w;

    assign accept   = (st_q == ST_IDLE) && start_i;
    assign zero_req = (count_i == '0);
    assign load     = accept && !zero_req;
    assign step     = (st_q == ST_WRITE);
    assign finish   = step && last_w;
    assign pix_w    = rgb_t'(pal_rdata_i);

    pal_gray_walker #(.DEPTH(PAL_DEPTH)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .base_i  (base_i),
        .count_i (count_i),
        .step_i  (step),
        .idx_o   (idx_w),
        .last_o  (last_w)
    );

    pal_gray_luma u_luma (
        .pix_i  (pix_w),
        .gray_o (gray_w)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (load) st_d = ST_READ;
            ST_READ:  st_d = ST_CALC;
            ST_CALC:  st_d = ST_WRITE;
            ST_WRITE: st_d = last_w ? ST_IDLE : ST_READ;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            gray_q  <= '0;
            done_q  <= 1'b0;
            blank_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (accept && zero_req) || finish;
            if (st_q == ST_CALC)
                gray_q <= gray_w;
            if (load)
                blank_q <= 1'b1;
            else if (finish)
                blank_q <= 1'b0;
        end
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign blank_o     = blank_q;
    assign done_o      = done_q;
    assign pal_addr_o  = idx_w;
    assign pal_we_o    = step;
    assign pal_wdata_o = gray_entry(gray_q);

    // R6: blanking register follows the FSM's busy span
    p_blank_busy_r6: assert property (@(posedge clk) disable iff (rst)
        blank_o == busy_o);

    // R5: never two write strobes in adjacent cycles
    p_write_gap_r5: assert property (@(posedge clk) disable iff (rst)
        pal_we_o |=> !pal_we_o);

    // R5: address held from read through write
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CALC || st_q == ST_WRITE) |-> $stable(pal_addr_o));

    // R4: after a non-final write the address moves to the next entry
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (pal_we_o && !last_w) |=> (pal_addr_o ==
            (($past(pal_addr_o) == AW'(PAL_DEPTH - 1)) ? AW'(0)
                                                        : $past(pal_addr_o) + AW'(1))));

    // R7: completion is a single pulse unless a new start arrives
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o);

    // R8: zero-count start completes at once without writing
    p_zero_count_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start_i && count_i == '0) |=> (done_o && !busy_o && !pal_we_o));

    // R9: a start while busy does not restart the pass
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_READ && start_i) |=> (st_q == ST_CALC && $stable(pal_addr_o)));

endmodule

// File: tb/pal_gray_engine_tb.sv
`timescale 1ns/1ps
module pal_gray_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  base_i = '0;
    logic [8:0]  count_i = '0;
    logic        busy_o, blank_o, done_o, pal_we_o;
    logic [7:0]  pal_addr_o;
    logic [17:0] pal_rdata_i, pal_wdata_o;

    logic [17:0] mem [256];
    logic [17:0] ref_mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [17:0] ld_data = '0;

    int          exp_addr_q[$];
    logic [17:0] exp_data_q[$];
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    pal_gray_engine u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .base_i      (base_i),
        .count_i     (count_i),
        .busy_o      (busy_o),
        .blank_o     (blank_o),
        .done_o      (done_o),
        .pal_addr_o  (pal_addr_o),
        .pal_rdata_i (pal_rdata_i),
        .pal_wdata_o (pal_wdata_o),
        .pal_we_o    (pal_we_o)
    );

    // palette model: synchronous read, one-cycle latency
    always @(posedge clk) begin
        if (ld_en)
            mem[ld_addr] <= ld_data;
        else if (pal_we_o)
            mem[pal_addr_o] <= pal_wdata_o;
        pal_rdata_i <= mem[pal_addr_o];
    end

    function automatic void check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    function automatic logic [5:0] ref_gray(input logic [17:0] e);
        int s;
        s = 77 * int'(e[17:12]) + 151 * int'(e[11:6]) + 28 * int'(e[5:0]) + 128;
        s = s >> 8;
        if (s > 63) s = 63;
        return s[5:0];
    endfunction

    // monitor: compares each write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && pal_we_o) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R9 unexpected write", int'(pal_addr_o), -1);
            end else begin
                int          ea;
                logic [17:0] ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(int'(pal_addr_o) == ea, "R4 write address", int'(pal_addr_o), ea);
                check(pal_wdata_o == ed, "R1 R3 write data", int'(pal_wdata_o), int'(ed));
            end
        end
    end

    task automatic load_entry(input int a, input logic [17:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a[7:0]; ld_data = d;
        ref_mem[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_op(input int base, input int cnt, input bit poke, input string req);
        int  k;
        bit  we_ok;
        int  exp_k;
        for (int i = 0; i < cnt; i++) begin
            int          a;
            logic [5:0]  g;
            a = (base + i) % 256;
            g = ref_gray(ref_mem[a]);
            ref_mem[a] = {g, g, g};
            exp_addr_q.push_back(a);
            exp_data_q.push_back({g, g, g});
        end
        @(negedge clk);
        start_i = 1'b1; base_i = base[7:0]; count_i = cnt[8:0];
        k = 0;
        we_ok = 1'b1;
        exp_k = 3 * cnt + 1;
        while (k < 2000) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                start_i = 1'b0;
                check(blank_o == (cnt != 0), "R6 blank after start", int'(blank_o), int'(cnt != 0));
            end
            if (poke && k == 4) begin
                start_i = 1'b1; base_i = 8'd200; count_i = 9'd7;
            end
            if (poke && k == 5) start_i = 1'b0;
            if (pal_we_o != (k % 3 == 0 && k <= 3 * cnt)) we_ok = 1'b0;
            if (done_o) break;
        end
        check(k == exp_k, {req, " R7 done cycle"}, k, exp_k);
        check(we_ok, "R5 write strobe cadence", int'(we_ok), 1);
        check(!blank_o && !busy_o, "R6 blank low at done", int'(blank_o), 0);
        @(negedge clk);
        check(!done_o, "R7 single done pulse", int'(done_o), 0);
        check(exp_addr_q.size() == 0, {req, " all writes seen"}, exp_addr_q.size(), 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 256; i++)
                if (mem[i] !== ref_mem[i]) bad++;
            check(bad == 0, {req, " R4 palette contents"}, bad, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !blank_o && !done_o && !pal_we_o, "R11 reset state",
              int'({busy_o, blank_o, done_o, pal_we_o}), 0);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) begin
            logic [5:0] r, g, b;
            r = i[5:0];
            g = 6'((i * 7) % 64);
            b = 6'((i * 13 + 5) % 64);
            load_entry(i, {r, g, b});
        end
        run_op(10, 5, 1'b0, "R1");
        load_entry(40, {6'd63, 6'd63, 6'd63});
        load_entry(41, {6'd63, 6'd0, 6'd0});
        run_op(40, 2, 1'b0, "R2");
        check(mem[40] == {6'd63, 6'd63, 6'd63}, "R2 full scale", int'(mem[40]), int'({6'd63, 6'd63, 6'd63}));
        check(mem[41] == {6'd19, 6'd19, 6'd19}, "R3 red only", int'(mem[41]), int'({6'd19, 6'd19, 6'd19}));
        run_op(254, 4, 1'b0, "R4 wrap");
        run_op(100, 0, 1'b0, "R8 zero count");
        run_op(60, 3, 1'b1, "R9 busy start");
        run_op(0, 256, 1'b0, "R10 full palette");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule